// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block is a free-running timer with a programmable prescaler and wrap limit, plus a set of capture channels that all watch one external trigger line. The trigger is first brought into the clock domain through a two-stage synchroniser. Edges are then detected on the synchronised level. Each channel has its own enable and edge selection. When a channel sees its edge, it copies the live counter value into its capture register and raises its capture flag. It raises an overcapture flag instead of losing the event silently when its capture flag had not yet been cleared.

The usual setup puts channel 0 on the rising edge and channel 1 on the falling edge. Software then subtracts the two captures to get the high time of the trigger in counter ticks. Software drives the block through a simple register write port and a combinational read port. Typical steps are to stop the counter, set the prescaler and wrap limit, choose the channel modes, issue an update event to zero the counter, clear the flags, and start counting. One interrupt line combines every flag that is both set and enabled.

Register addresses: 0 control (bit 0 = count enable), 1 prescaler, 2 wrap limit, 3 channel configuration, 4 update event (write-only), 5 status, 6 interrupt enable, 7 live counter, 8 + i capture of channel i.

Top module: `ecap_capture_unit`

## Requirements
- R1: After reset the counter, every capture register, every flag and the interrupt enables are zero, counting is off and `irq` is low.
- R2: While count enable (control bit 0) is set, the counter advances by one every prescaler + 1 clock cycles.
- R3: When the counter is advanced while equal to the wrap limit, its next value is zero.
- R4: Writing zero to the control register stops the counter, and it then holds its value.
- R5: Writing 1 to bit 0 of the update-event register sets the counter and the prescaler phase to zero on that clock edge, even while counting.
- R6: The configuration field of channel i is bits 2i+1 (capture enable) and 2i (edge: 0 rising, 1 falling). When enabled, the selected trigger edge latches the counter into the channel's capture register on the third rising clock edge after the input changes, and the channel's flag is then set.
- R7: A channel whose capture-enable bit is 0 ignores trigger edges: its flag and capture register are left unchanged.
- R8: Status bits 0..NCH-1 are capture flags and bits NCH..2NCH-1 are overcapture flags. Writing 1 to a status bit clears it, and writing 0 leaves it. With two channels, writing 0x0F clears all flags.
- R9: A capture on a channel whose capture flag is still set sets that channel's overcapture flag.
- R10: `irq` is high exactly when some status bit and the interrupt-enable bit at the same position are both set.
- R11: With channel 0 on rising and channel 1 on falling edges, and a prescaler of zero, capture 1 minus capture 0 equals the trigger's high time in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line shared by all channels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted prescaler phase or counter shows up as a wrong live count, or as a wrong capture value, within one prescaler period. A missing or doubled synchroniser stage moves the flag's appearance by a clock cycle. The bench samples the flag on both sides of the third edge after a trigger change. A flag that is wrongly held or dropped appears in the status read, and through `irq`, in the same cycle as the clearing write. The difference between the two captures exposes any unequal latency between the edge paths.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 4'd0,
        REG_PSC    = 4'd1,
        REG_WRAP   = 4'd2,
        REG_CHCFG  = 4'd3,
        REG_UPDATE = 4'd4,
        REG_STATUS = 4'd5,
        REG_IRQEN  = 4'd6,
        REG_COUNT  = 4'd7,
        REG_CAP0   = 4'd8
    } reg_addr_e;

    // per-channel setting: bit 1 enables capture, bit 0 picks the falling edge
    typedef struct packed {
        logic enable;
        logic falling;
    } ch_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic logic edge_hit(edge_evt_t e, ch_cfg_t c);
        return c.enable & (c.falling ? e.fall : e.rise);
    endfunction

endpackage

// File: rtl/ecap_sync_edge.sv
module ecap_sync_edge
    import ecap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_in,
    output edge_evt_t evt
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    always_comb begin
        evt.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
        evt.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             upd,
    input  logic [CNT_W-1:0] psc,
    input  logic [CNT_W-1:0] wrap,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    logic [CNT_W-1:0] phase_q;

    assign tick = run & ~upd & (phase_q >= psc);

    always_ff @(posedge clk) begin
        if (rst || upd) begin
            phase_q <= '0;
            count   <= '0;
        end else if (run) begin
            if (tick) begin
                phase_q <= '0;
                count   <= (count == wrap) ? '0 : count + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
    import ecap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg,
    input  edge_evt_t        evt,
    input  logic [CNT_W-1:0] count,
    input  logic             clr_flag,
    input  logic             clr_ovr,
    output logic [CNT_W-1:0] cap_q,
    output logic             flag_q,
    output logic             ovr_q
);
    logic hit;
    assign hit = edge_hit(evt, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (hit) cap_q <= count;
            flag_q <= hit | (flag_q & ~clr_flag);
            ovr_q  <= (hit & flag_q) | (ovr_q & ~clr_ovr);
        end
    end
endmodule

// File: rtl/ecap_capture_unit.sv
module ecap_capture_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int FLAG_W = 2 * NCH;
    localparam int CFG_W  = 2 * NCH;

    logic              run_q;
    logic [CNT_W-1:0]  psc_q;
    logic [CNT_W-1:0]  wrap_q;
    logic [CFG_W-1:0]  chcfg_q;
    logic [FLAG_W-1:0] irqen_q;
    logic [CNT_W-1:0]  count;
    logic              tick;
    logic              upd;
    logic              wr_status;
    edge_evt_t         evt;
    logic [NCH-1:0]    flag;
    logic [NCH-1:0]    ovr;
    logic [CNT_W-1:0]  cap [NCH];
    logic [FLAG_W-1:0] status;

    assign upd       = wr_en && (wr_addr == REG_UPDATE) && wr_data[0];
    assign wr_status = wr_en && (wr_addr == REG_STATUS);
    assign status    = {ovr, flag};
    assign irq       = |(status & irqen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            psc_q   <= '0;
            wrap_q  <= '0;
            chcfg_q <= '0;
            irqen_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL:  run_q   <= wr_data[0];
                REG_PSC:   psc_q   <= wr_data;
                REG_WRAP:  wrap_q  <= wr_data;
                REG_CHCFG: chcfg_q <= wr_data[CFG_W-1:0];
                REG_IRQEN: irqen_q <= wr_data[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    ecap_sync_edge #(.STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .async_in(trig_in), .evt(evt)
    );

    ecap_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst(rst), .run(run_q), .upd(upd),
        .psc(psc_q), .wrap(wrap_q), .count(count), .tick(tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ecap_channel #(.CNT_W(CNT_W)) ch_i (
            .clk(clk), .rst(rst),
            .cfg(ch_cfg_t'(chcfg_q[2*i +: 2])),
            .evt(evt), .count(count),
            .clr_flag(wr_status & wr_data[i]),
            .clr_ovr(wr_status & wr_data[NCH + i]),
            .cap_q(cap[i]), .flag_q(flag[i]), .ovr_q(ovr[i])
        );
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL:   rd_data = CNT_W'(run_q);
            REG_PSC:    rd_data = psc_q;
            REG_WRAP:   rd_data = wrap_q;
            REG_CHCFG:  rd_data = CNT_W'(chcfg_q);
            REG_STATUS: rd_data = CNT_W'(status);
            REG_IRQEN:  rd_data = CNT_W'(irqen_q);
            REG_COUNT:  rd_data = count;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(int'(REG_CAP0) + i)) rd_data = cap[i];
        end
    end
endmodule

// File: rtl/ecap_capture_unit_chk.sv
module ecap_capture_unit_chk
    import ecap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              run_q,
    input logic              upd,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  wrap_q,
    input logic [NCH-1:0]    flag,
    input logic [NCH-1:0]    ovr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0) && !irq && (flag == '0) && (ovr == '0));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count == wrap_q) |=> (count == '0));

    assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !upd) |=> $stable(count));

    assert_update_zero_R5: assert property (@(posedge clk) disable iff (rst)
        upd |=> (count == '0));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag[0] && !(wr_en && wr_addr == REG_STATUS && wr_data[0])) |=> flag[0]);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flag != '0) || (ovr != '0)));
endmodule

bind ecap_capture_unit ecap_capture_unit_chk #(.CNT_W(CNT_W), .NCH(NCH)) chk_i (
    .clk(clk), .rst(rst), .irq(irq), .run_q(run_q), .upd(upd), .tick(tick),
    .count(count), .wrap_q(wrap_q), .flag(flag), .ovr(ovr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/ecap_capture_unit_tb_top.sv
module ecap_capture_unit_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_in = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [3:0]       rd_addr = '0;
    logic [CNT_W-1:0] rd_data;
    logic             irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic [CNT_W-1:0] v, c0, c1;

    always #4 clk = ~clk;

    ecap_capture_unit #(.CNT_W(CNT_W), .NCH(2)) dut_i (
        .clk(clk), .rst(rst), .trig_in(trig_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [CNT_W-1:0] val);
        rd_addr = 4'(a);
        #1 val = rd_data;
    endtask

    task automatic pulse(int high);
        trig_in = 1'b1;
        repeat (high) @(negedge clk);
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        rd(7, v); check("R1 count", v, 0);
        rd(5, v); check("R1 status", v, 0);
        rd(8, v); check("R1 cap0", v, 0);
        rd(0, v); check("R1 ctrl", v, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_prescale_stop();
        wr(1, 3); wr(2, 16'hFFFF); wr(4, 1); wr(0, 1);
        repeat (20) @(negedge clk);
        rd(7, v); check("R2 count after 20 cycles psc=3", v, 5);
        wr(0, 0);
        repeat (10) @(negedge clk);
        rd(7, v); check("R4 count held after stop", v, 5);
    endtask

    task automatic t_wrap_update();
        wr(1, 0); wr(2, 4); wr(4, 1); wr(0, 1);
        repeat (7) @(negedge clk);
        rd(7, v); check("R3 count wraps at 4", v, 2);
        wr(4, 1);
        rd(7, v); check("R5 update zeroes running counter", v, 0);
        wr(0, 0);
    endtask

    task automatic t_latency();
        wr(2, 16'hFFFF); wr(4, 1); wr(0, 1);
        repeat (9) @(negedge clk);
        wr(0, 0);
        rd(7, v); check("R2 count psc=0", v, 10);
        wr(3, 16'hE); wr(5, 16'hF);
        trig_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(5, v); check("R6 no flag before third edge", v, 0);
        @(negedge clk);
        rd(5, v); check("R6 rise flag at third edge", v, 1);
        rd(8, v); check("R6 cap0 value", v, 10);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(5, v); check("R6 falling flag on ch1", v, 3);
        rd(9, v); check("R6 cap1 value", v, 10);
    endtask

    task automatic t_mode_off();
        wr(5, 16'hF); wr(3, 0); wr(4, 1);
        pulse(4);
        rd(5, v); check("R7 disabled channels keep flags clear", v, 0);
        rd(8, v); check("R7 cap0 unchanged", v, 10);
    endtask

    task automatic t_width();
        wr(3, 16'hE); wr(4, 1); wr(0, 1);
        repeat (3) @(negedge clk);
        pulse(13);
        wr(0, 0);
        rd(8, c0); rd(9, c1);
        check("R11 pulse width", int'(c1 - c0), 13);
        rd(5, v); check("R8 both flags set", v, 3);
    endtask

    task automatic t_w1c();
        wr(5, 1);
        rd(5, v); check("R8 clear only bit 0", v, 2);
        wr(5, 0);
        rd(5, v); check("R8 zero write leaves flags", v, 2);
        wr(5, 16'hF);
        rd(5, v); check("R8 0x0F clears all", v, 0);
    endtask

    task automatic t_overcapture();
        pulse(3);
        rd(5, v); check("R9 single capture no over", v, 3);
        pulse(3);
        rd(5, v); check("R9 overcapture flags", v, 15);
        wr(5, 16'hF);
        rd(5, v); check("R9 over flags cleared", v, 0);
    endtask

    task automatic t_irq();
        wr(6, 0);
        pulse(3);
        check("R10 irq masked", irq, 0);
        wr(6, 1);
        #1 check("R10 irq ch0 enabled", irq, 1);
        wr(6, 4);
        #1 check("R10 irq only over enabled", irq, 0);
        wr(6, 3); wr(5, 1);
        #1 check("R10 irq from ch1 remains", irq, 1);
        wr(5, 2);
        #1 check("R10 irq drops when cleared", irq, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescale_stop();
        t_wrap_update();
        t_latency();
        t_mode_off();
        t_width();
        t_w1c();
        t_overcapture();
        t_irq();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule